// File: doc/BRIEF.md
# Memory-Mapped Factorial Coprocessor

This block is a small register-mapped coprocessor that a host CPU drives through a plain read/write register port. The host writes an operand into the operand register. A sequential engine then forms the factorial of that operand with one 32-bit multiply per clock, counting the operand down. When it finishes, the truncated product replaces the operand in the same register. While the engine runs, a busy flag in the status register is set, and the host is expected to poll that flag before it reads the result.

Besides the engine, the register map holds a constant identification word, a scratch word that stores the bitwise inverse of whatever is written to it, and a status register. The status register carries the busy flag and a host-writable enable for the completion interrupt. When that enable is set, each completion drives a single-cycle pulse on bit 0 of a cause vector, which feeds an external interrupt aggregator. Accesses are checked for size: below offset 0x80 only 4-byte accesses take effect.

Top module: `fact_copro`

## Requirements
- R1: A 4-byte read of offset 0x00 returns the constant 0x010000ED.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the written data, and a 4-byte read of 0x04 returns the stored word.
- R3: A 4-byte write to offset 0x08 while the engine is idle loads the operand and sets status bit 0 (busy) from the next cycle on. While busy, a read of 0x08 returns the operand that was written.
- R4: On completion, offset 0x08 holds the product n*(n-1)*...*1 modulo 2^32, with an operand of 0 giving 1. Busy clears in the same cycle that the result is stored. While the running product is nonzero, busy stays high for max(n,1) cycles.
- R5: When the running product becomes 0 modulo 2^32, the engine stops at once with result 0. Any operand therefore finishes within 40 cycles.
- R6: A write to 0x08 while busy is ignored. Neither the operand nor the final result is affected.
- R7: Status bit 7 at offset 0x20 is a read/write interrupt enable. Busy (bit 0) cannot be set or cleared by writing the status register, and all other status bits read 0.
- R8: When the enable is set at completion, irq_cause bit 0 is high for exactly the one cycle after busy clears. When the enable is clear, no pulse occurs. The other irq_cause bits are always 0.
- R9: Below offset 0x80, an access whose size is not 4 bytes is ignored on write and reads back 0xFFFFFFFF.
- R10: Reads of unmapped offsets (for example 0x0C and 0x80) return 0xFFFFFFFF, and writes to them change no register.
- R11: After reset, the scratch, operand and status registers read 0 and irq_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe; read data is combinational |
| host_addr | input | 8 | Byte offset of the access |
| host_size | input | 4 | Access size in bytes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, all ones when nothing is selected |
| irq_cause | output | 8 | Interrupt cause pulses; bit 0 is factorial completion |

## Verification
The bench targets the operand edges 0 and 1, a value whose product first overflows 32 bits, and operands large enough to drive the product to zero. A design that mishandled these would return 0 instead of 1, fail to truncate, or run for billions of cycles. It writes the operand again mid-computation, and a design that did not lock out such writes would restart or corrupt the result. It also checks the exact busy length, whether the completion pulse appears with the enable set and clear, and the rejection of 1-, 2- and 8-byte accesses. An engine that was off by one cycle, an interrupt that ignored the enable, or a register that latched a wrong-size write would each show up at the ports.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SIZE_W = 4;
  localparam int CAUSE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_IDENT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SCRATCH = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_OPERAND = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_WIDE    = 8'h80;

  localparam logic [DATA_W-1:0] IDENT_WORD = 32'h0100_00ED;
  localparam int BUSY_BIT = 0;
  localparam int IEN_BIT  = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_IDENT, SEL_SCRATCH, SEL_OPERAND, SEL_STATUS
  } reg_sel_e;

  function automatic logic size_legal(input logic [ADDR_W-1:0] addr,
                                      input logic [SIZE_W-1:0] size);
    return (addr < OFF_WIDE) && (size == SIZE_W'(4));
  endfunction

  function automatic logic [DATA_W-1:0] trunc_mul(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] full;
    full = a * b;
    return full[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/fact_decode.sv
module fact_decode
  import fact_pkg::*;
(
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [SIZE_W-1:0] host_size,
  output reg_sel_e          rd_sel,
  output logic              wr_scratch,
  output logic              wr_operand,
  output logic              wr_status
);
  logic     legal;
  reg_sel_e hit;

  assign legal = size_legal(host_addr, host_size);

  always_comb begin
    unique case (host_addr)
      OFF_IDENT:   hit = SEL_IDENT;
      OFF_SCRATCH: hit = SEL_SCRATCH;
      OFF_OPERAND: hit = SEL_OPERAND;
      OFF_STATUS:  hit = SEL_STATUS;
      default:     hit = SEL_NONE;
    endcase
  end

  assign rd_sel     = (host_rd && legal) ? hit : SEL_NONE;
  assign wr_scratch = host_wr && legal && (hit == SEL_SCRATCH);
  assign wr_operand = host_wr && legal && (hit == SEL_OPERAND);
  assign wr_status  = host_wr && legal && (hit == SEL_STATUS);
endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  output logic              busy,
  output logic              done_evt,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] cnt_q;
  logic              busy_q;
  logic              last_step;
  logic              prod_zero;

  // Stop when no factors remain or the product can no longer change.
  assign last_step = (cnt_q <= DATA_W'(1));
  assign prod_zero = (acc_q == '0);
  assign done_evt  = busy_q && (last_step || prod_zero);
  assign busy      = busy_q;
  assign result    = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      acc_q  <= DATA_W'(1);
      cnt_q  <= operand;
      busy_q <= 1'b1;
    end else if (done_evt) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      acc_q <= trunc_mul(acc_q, cnt_q);
      cnt_q <= cnt_q - DATA_W'(1);
    end
  end
endmodule

// File: rtl/fact_rdmux.sv
module fact_rdmux
  import fact_pkg::*;
(
  input  reg_sel_e          rd_sel,
  input  logic [DATA_W-1:0] scratch_q,
  input  logic [DATA_W-1:0] op_q,
  input  logic              busy,
  input  logic              irq_en_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word           = '0;
    status_word[BUSY_BIT] = busy;
    status_word[IEN_BIT]  = irq_en_q;
  end

  always_comb begin
    unique case (rd_sel)
      SEL_IDENT:   rdata = IDENT_WORD;
      SEL_SCRATCH: rdata = scratch_q;
      SEL_OPERAND: rdata = op_q;
      SEL_STATUS:  rdata = status_word;
      default:     rdata = '1;
    endcase
  end
endmodule

// File: rtl/fact_copro.sv
module fact_copro
  import fact_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [SIZE_W-1:0]  host_size,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic [CAUSE_W-1:0] irq_cause
);
  reg_sel_e          rd_sel;
  logic              wr_scratch;
  logic              wr_operand;
  logic              wr_status;
  logic              busy;
  logic              done_evt;
  logic              start_evt;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] op_q;
  logic              irq_en_q;
  logic              irq_q;

  fact_decode decode_i (
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_size (host_size),
    .rd_sel    (rd_sel),
    .wr_scratch(wr_scratch),
    .wr_operand(wr_operand),
    .wr_status (wr_status)
  );

  // Operand writes are locked out while the engine runs.
  assign start_evt = wr_operand && !busy;

  fact_engine engine_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .operand (host_wdata),
    .busy    (busy),
    .done_evt(done_evt),
    .result  (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      op_q      <= '0;
      irq_en_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_scratch) scratch_q <= ~host_wdata;
      if (start_evt)     op_q <= host_wdata;
      else if (done_evt) op_q <= result;
      if (wr_status) irq_en_q <= host_wdata[IEN_BIT];
      irq_q <= done_evt && irq_en_q;
    end
  end

  always_comb begin
    irq_cause    = '0;
    irq_cause[0] = irq_q;
  end

  fact_rdmux rdmux_i (
    .rd_sel   (rd_sel),
    .scratch_q(scratch_q),
    .op_q     (op_q),
    .busy     (busy),
    .irq_en_q (irq_en_q),
    .rdata    (host_rdata)
  );
endmodule

// File: rtl/fact_copro_chk.sv
module fact_copro_chk
  import fact_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr,
  input logic               host_rd,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [SIZE_W-1:0]  host_size,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [DATA_W-1:0]  host_rdata,
  input logic [CAUSE_W-1:0] irq_cause,
  input logic               start_evt,
  input logic               done_evt,
  input logic               busy,
  input logic [DATA_W-1:0]  op_q,
  input logic [DATA_W-1:0]  scratch_q,
  input logic               irq_en_q
);
  assert_ident_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == OFF_IDENT && host_size == SIZE_W'(4))
      |-> host_rdata == IDENT_WORD);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_clear_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_evt));

  assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt && host_wr && host_addr == OFF_OPERAND) |=> $stable(op_q));

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && irq_en_q) |=> irq_cause[0]);

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cause[0] |-> $past(done_evt));

  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFF_SCRATCH && host_size != SIZE_W'(4))
      |=> $stable(scratch_q));
endmodule

bind fact_copro fact_copro_chk chk_i (.*);

// File: tb/fact_copro_tb.sv
module fact_copro_tb_top;
  import fact_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               host_wr = 1'b0;
  logic               host_rd = 1'b0;
  logic [ADDR_W-1:0]  host_addr = '0;
  logic [SIZE_W-1:0]  host_size = 4'd4;
  logic [DATA_W-1:0]  host_wdata = '0;
  logic [DATA_W-1:0]  host_rdata;
  logic [CAUSE_W-1:0] irq_cause;

  int checks = 0;
  int fails = 0;
  logic [31:0] rv;
  int lat;

  always #4 clk = ~clk;

  fact_copro dut_i (.*);

  localparam int NVEC = 7;
  localparam logic [31:0] VEC_N [NVEC] = '{0, 1, 2, 5, 10, 12, 13};
  localparam logic [31:0] VEC_P [NVEC] =
    '{32'd1, 32'd1, 32'd2, 32'd120, 32'd3628800, 32'd479001600, 32'h7328_CC00};

  function automatic logic [31:0] model_fact(input logic [31:0] n);
    logic [63:0] p = 64'd1;
    for (int i = 2; i <= 40 && i <= int'(n); i++) p = (p * 64'(i)) & 64'hFFFF_FFFF;
    if (n > 40) p = 64'd0;
    return p[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'd4);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d; host_size = s;
    @(posedge clk); #1;
    host_wr = 1'b0; host_size = 4'd4;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] s = 4'd4);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a; host_size = s;
    #1 d = host_rdata;
    host_rd = 1'b0; host_size = 4'd4;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] st;
    cyc = 0;
    rd(OFF_STATUS, st);
    while (st[0] && cyc < 200) begin
      cyc++;
      rd(OFF_STATUS, st);
    end
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(OFF_SCRATCH, rv); check("R11 scratch", rv, 0);
    rd(OFF_OPERAND, rv); check("R11 operand", rv, 0);
    rd(OFF_STATUS, rv);  check("R11 status", rv, 0);
    check("R11 irq", 32'(irq_cause), 0);

    rd(OFF_IDENT, rv); check("R1 ident", rv, 32'h0100_00ED);

    wr(OFF_SCRATCH, 32'h1234_5678);
    rd(OFF_SCRATCH, rv); check("R2 inverse", rv, 32'hEDCB_A987);

    // Table walk: R4 results and latency, R8 pulse with enable set
    wr(OFF_STATUS, 32'h80);
    rd(OFF_STATUS, rv); check("R7 enable set", rv, 32'h80);
    for (int i = 0; i < NVEC; i++) begin
      wr(OFF_OPERAND, VEC_N[i]);
      wait_done(lat);
      check("R8 pulse", 32'(irq_cause), 1);
      check("R4 latency", lat, (VEC_N[i] == 0) ? 1 : VEC_N[i]);
      rd(OFF_OPERAND, rv); check("R4 result", rv, VEC_P[i]);
      check("R8 pulse width", 32'(irq_cause), 0);
    end

    // R3 busy and operand visibility, R6 lockout
    wr(OFF_OPERAND, 32'd20);
    rd(OFF_STATUS, rv); check("R3 busy", rv, 32'h81);
    rd(OFF_OPERAND, rv); check("R3 operand while busy", rv, 32'd20);
    wr(OFF_OPERAND, 32'd3);
    rd(OFF_OPERAND, rv); check("R6 lockout", rv, 32'd20);
    wait_done(lat);
    rd(OFF_OPERAND, rv); check("R6 result", rv, model_fact(32'd20));

    // R7 busy not writable, enable cleared; R8 no pulse when disabled
    wr(OFF_STATUS, 32'h01);
    rd(OFF_STATUS, rv); check("R7 busy read-only", rv, 32'h00);
    wr(OFF_OPERAND, 32'd4);
    wait_done(lat);
    check("R8 no pulse", 32'(irq_cause), 0);
    repeat (2) begin
      @(negedge clk); check("R8 stays low", 32'(irq_cause), 0);
    end
    rd(OFF_OPERAND, rv); check("R4 four", rv, 32'd24);

    // R5 product-zero early exit
    wr(OFF_OPERAND, 32'd34);
    wait_done(lat);
    rd(OFF_OPERAND, rv); check("R5 34", rv, 32'd0);
    wr(OFF_OPERAND, 32'hFFFF_FFFF);
    wait_done(lat);
    check("R5 bounded", 32'(lat <= 40), 1);
    rd(OFF_OPERAND, rv); check("R5 max", rv, 32'd0);

    // R9 size filtering
    wr(OFF_SCRATCH, 32'h0000_FFFF, 4'd2);
    wr(OFF_SCRATCH, 32'h0000_FFFF, 4'd8);
    rd(OFF_SCRATCH, rv); check("R9 write ignored", rv, 32'hEDCB_A987);
    rd(OFF_IDENT, rv, 4'd1); check("R9 read ones", rv, 32'hFFFF_FFFF);
    wr(OFF_OPERAND, 32'd3, 4'd8);
    rd(OFF_STATUS, rv); check("R9 no start", rv, 32'h0);

    // R10 unmapped
    rd(8'h0C, rv); check("R10 0x0C", rv, 32'hFFFF_FFFF);
    rd(8'h80, rv); check("R10 0x80", rv, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h55);
    wr(8'h80, 32'h55);
    rd(OFF_SCRATCH, rv); check("R10 scratch kept", rv, 32'hEDCB_A987);
    rd(OFF_OPERAND, rv); check("R10 operand kept", rv, 32'd0);
    rd(OFF_STATUS, rv);  check("R10 status kept", rv, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule